// File: doc/BRIEF.md
# Serial Configuration Loader Sequencer

This block loads a configuration bitstream into a target device that has a slave-serial configuration port. It drives three pins toward the target: a program strobe, a configuration clock and a serial data line. It watches two status lines coming back from the target: an initialisation line and a completion line. A one-cycle start pulse begins a job. The block then resets the target through a three-phase handshake, streams the configuration words, and waits for the target to report completion.

The bitstream comes from an upstream producer through a valid/ready word interface. Each word is `DATA_W` bits wide and carries a flag that marks the final word. The block shifts every bit out with its own clock pulse, and each pulse goes through a fixed four-step pin pattern. Each of the three waits on the target has its own timeout, measured in ticks of `TICK_CYC` system clocks. A timeout ends the job with an error code that names the phase that failed. The two status inputs pass through a two-stage synchronizer before the control logic uses them.

Top module: `serial_cfg_seq`

## Requirements
- R1: After reset, and at any time no job is running, `busy_o` is 0 and the pins are idle: the program strobe is at its inactive level, `cclk_o` is 1 and `sdata_o` is 1. `result_o` reads 0 after reset.
- R2: A `start` pulse while idle drives the program strobe to its active level from the next clock edge and raises `busy_o`. The active level is low when `PROG_ACT_HIGH` is 0 and high when it is 1.
- R3: While the strobe is active, if the synchronized init line does not go low before the timeout, the job ends with `result_o` = 1 and the strobe returns to inactive.
- R4: Once init is seen low, the strobe is released at once while `busy_o` stays high. If init does not then return high before the timeout, the job ends with `result_o` = 2.
- R5: Each bit takes four cycles with these pin values (clock, data): (0,1), (0,b), (1,b), (1,1). Data is therefore stable across every rising clock, data only falls while the clock is low, and data is 1 in the first cycle after every falling clock.
- R6: Words are accepted only in the load phase, and only when the previous word has been fully shifted out. Words leave in the order they were accepted, most significant bit first.
- R7: After the word flagged last has been shifted out, if the done line does not go high before the timeout, the job ends with `result_o` = 3.
- R8: If done goes high within the window, the job ends with `result_o` = 0. `result_o` changes only when a job ends.
- R9: Every wait times out after exactly (POLL_LIMIT+2)·TICK_CYC cycles in that phase. If init never responds, `busy_o` stays high for exactly that many cycles after the edge that samples `start`.
- R10: A `start` pulse while `busy_o` is high is ignored. It neither restarts nor extends the running job.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a configuration job |
| cfg_valid | input | 1 | Upstream word is valid |
| cfg_data | input | DATA_W | Upstream configuration word, sent MSB first |
| cfg_last | input | 1 | Marks the final word of the bitstream |
| cfg_ready | output | 1 | Block accepts the presented word this cycle |
| init_i | input | 1 | Target initialisation status (asynchronous) |
| done_i | input | 1 | Target completion status (asynchronous) |
| prog_o | output | 1 | Program strobe toward the target |
| cclk_o | output | 1 | Configuration clock toward the target |
| sdata_o | output | 1 | Serial configuration data toward the target |
| busy_o | output | 1 | A job is in progress |
| result_o | output | 2 | Outcome of the last job: 0 ok, 1 init never cleared, 2 init never returned, 3 done never rose |

## Verification
The bench plays the target. It answers each handshake phase correctly in some jobs and leaves a chosen phase unanswered in others, so that each of the three error codes is told apart from success and from the other two. Two successful jobs use different word patterns: alternating bits, nibble runs, all zeros, all ones, and a word with only its end bits set. A scoreboard compares the data sampled at every rising configuration clock against the expected MSB-first stream, which exposes bit-order, word-order and dropped-bit faults. The pin values around every clock edge are checked to confirm the four-step pattern. An unanswered job has its busy time counted exactly, and a second start is pulsed during that job, which separates the correct timeout window from an off-by-one window and from a restart.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PROG_WAIT = 3'd1,
        ST_INIT_WAIT = 3'd2,
        ST_SHIFT     = 3'd3,
        ST_DONE_WAIT = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_NO_CLEAR = 2'd1,
        RES_NO_READY = 2'd2,
        RES_NO_DONE  = 2'd3
    } result_e;

    // synchronized status bits, index order matches the synchronizer vector
    typedef struct packed {
        logic done;
        logic init;
    } status_t;

    function automatic logic prog_pin(input logic assert_it, input bit act_high);
        return assert_it ? act_high : ~act_high;
    endfunction

endpackage

// File: rtl/cfgseq_sync.sv
module cfgseq_sync #(
    parameter int              W       = 2,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgseq_timer.sv
module cfgseq_timer #(
    parameter int TICK_CYC   = 50000,
    parameter int WAIT_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic expired
);
    localparam int CW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
    localparam int TW = $clog2(WAIT_TICKS + 1);
    localparam logic [CW-1:0] CYC_LAST  = CW'(TICK_CYC - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(WAIT_TICKS - 1);

    logic [CW-1:0] cyc;
    logic [TW-1:0] ticks;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cyc   <= '0;
            ticks <= '0;
        end else if (cyc == CYC_LAST) begin
            cyc   <= '0;
            ticks <= ticks + 1'b1;
        end else begin
            cyc <= cyc + 1'b1;
        end
    end

    assign expired = (cyc == CYC_LAST) && (ticks == TICK_LAST);
endmodule

// File: rtl/cfgseq_shift.sv
module cfgseq_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              cclk,
    output logic              sdata,
    output logic              finished
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

    logic [DATA_W-1:0] word;
    logic              last_q;
    logic [1:0]        step;
    logic [IW-1:0]     idx;
    logic              active;

    assign in_ready = enable && !active;

    always_ff @(posedge clk) begin
        if (rst) begin
            word     <= '0;
            last_q   <= 1'b0;
            step     <= 2'd0;
            idx      <= '0;
            active   <= 1'b0;
            finished <= 1'b0;
        end else begin
            finished <= 1'b0;
            if (in_valid && in_ready) begin
                word   <= in_data;
                last_q <= in_last;
                step   <= 2'd0;
                idx    <= '0;
                active <= 1'b1;
            end else if (active) begin
                step <= step + 2'd1;
                if (step == 2'd3) begin
                    if (idx == IDX_LAST) begin
                        active   <= 1'b0;
                        finished <= last_q;
                    end else begin
                        idx  <= idx + 1'b1;
                        word <= word << 1;
                    end
                end
            end
        end
    end

    // step 0: clk low/data high, 1: data=bit, 2: clk high, 3: data back high
    assign cclk  = active ? step[1] : 1'b1;
    assign sdata = (active && (step == 2'd1 || step == 2'd2)) ? word[DATA_W-1] : 1'b1;

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cclk) |-> $stable(sdata));
    // R5
    data_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sdata) |-> !cclk);
endmodule

// File: rtl/serial_cfg_seq.sv
module serial_cfg_seq
    import cfgseq_pkg::*;
#(
    parameter int TICK_CYC      = 50000,
    parameter int POLL_LIMIT    = 3,
    parameter int DATA_W        = 8,
    parameter bit PROG_ACT_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cfg_valid,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic              cfg_last,
    output logic              cfg_ready,
    input  logic              init_i,
    input  logic              done_i,
    output logic              prog_o,
    output logic              cclk_o,
    output logic              sdata_o,
    output logic              busy_o,
    output logic [1:0]        result_o
);
    localparam int WAIT_TICKS = POLL_LIMIT + 2;

    seq_state_e state, state_nx;
    result_e    result_q, result_nx;
    status_t    stat;
    logic       expired, shift_fin, timer_clr;

    cfgseq_sync #(.W(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({done_i, init_i}),
        .q   (stat)
    );

    cfgseq_timer #(.TICK_CYC(TICK_CYC), .WAIT_TICKS(WAIT_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (timer_clr),
        .expired (expired)
    );

    cfgseq_shift #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .enable   (state == ST_SHIFT),
        .in_valid (cfg_valid),
        .in_data  (cfg_data),
        .in_last  (cfg_last),
        .in_ready (cfg_ready),
        .cclk     (cclk_o),
        .sdata    (sdata_o),
        .finished (shift_fin)
    );

    always_comb begin
        state_nx  = state;
        result_nx = result_q;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_PROG_WAIT;
            ST_PROG_WAIT:
                if (!stat.init) state_nx = ST_INIT_WAIT;
                else if (expired) begin
                    state_nx  = ST_IDLE;
                    result_nx = RES_NO_CLEAR;
                end
            ST_INIT_WAIT:
                if (stat.init) state_nx = ST_SHIFT;
                else if (expired) begin
                    state_nx  = ST_IDLE;
                    result_nx = RES_NO_READY;
                end
            ST_SHIFT: if (shift_fin) state_nx = ST_DONE_WAIT;
            ST_DONE_WAIT:
                if (stat.done) begin
                    state_nx  = ST_IDLE;
                    result_nx = RES_OK;
                end else if (expired) begin
                    state_nx  = ST_IDLE;
                    result_nx = RES_NO_DONE;
                end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign timer_clr = (state == ST_IDLE) || (state == ST_SHIFT) || (state_nx != state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            result_q <= RES_OK;
        end else begin
            state    <= state_nx;
            result_q <= result_nx;
        end
    end

    assign busy_o   = (state != ST_IDLE);
    assign result_o = result_q;
    assign prog_o   = prog_pin(state == ST_PROG_WAIT, PROG_ACT_HIGH);

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (prog_o == ~PROG_ACT_HIGH) && cclk_o && sdata_o);
    // R10
    start_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start));
    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !$past(busy_o)) |-> $stable(result_o));
    // R4
    clk_only_released_chk: assert property (@(posedge clk) disable iff (rst)
        !cclk_o |-> busy_o && (prog_o == ~PROG_ACT_HIGH));
endmodule

// File: tb/serial_cfg_seq_tb.sv
module serial_cfg_seq_tb;
    localparam int TICK   = 4;
    localparam int LIMIT  = 3;
    localparam int WINDOW = (LIMIT + 2) * TICK;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       cfg_valid = 1'b0;
    logic [7:0] cfg_data = '0;
    logic       cfg_last = 1'b0;
    logic       cfg_ready;
    logic       init_i = 1'b1;
    logic       done_i = 1'b0;
    logic       prog_o, cclk_o, sdata_o, busy_o;
    logic [1:0] result_o;

    int checks = 0;
    int errors = 0;
    logic exp_q[$];
    logic prev_cclk = 1'b1;

    always #10 clk = ~clk;

    serial_cfg_seq #(.TICK_CYC(TICK), .POLL_LIMIT(LIMIT), .DATA_W(8), .PROG_ACT_HIGH(1'b0)) u_dut (
        .clk(clk), .rst(rst), .start(start),
        .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg_last(cfg_last), .cfg_ready(cfg_ready),
        .init_i(init_i), .done_i(done_i),
        .prog_o(prog_o), .cclk_o(cclk_o), .sdata_o(sdata_o),
        .busy_o(busy_o), .result_o(result_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: scoreboard pop on every rising configuration clock
    always @(negedge clk) begin
        if (!rst) begin
            if (cclk_o && !prev_cclk) begin
                if (exp_q.size() == 0) chk("R6 unexpected bit", 1, 0);
                else chk("R6 bit value", int'(sdata_o), int'(exp_q.pop_front()));
            end
            if (!cclk_o && prev_cclk) chk("R5 data high after clock fall", int'(sdata_o), 1);
        end
        prev_cclk <= cclk_o;
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_prog(input logic lvl);
        while (prog_o !== lvl) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    // driver: present words and push the expected bits on acceptance
    task automatic send_words(input logic [7:0] w0, input logic [7:0] w1,
                              input logic [7:0] w2, input int n);
        logic [7:0] ws[3];
        ws = '{w0, w1, w2};
        for (int k = 0; k < n; k++) begin
            cfg_data  = ws[k];
            cfg_last  = (k == n - 1);
            cfg_valid = 1'b1;
            while (!cfg_ready) @(negedge clk);
            for (int b = 7; b >= 0; b--) exp_q.push_back(ws[k][b]);
            @(negedge clk);
        end
        cfg_valid = 1'b0;
        cfg_last  = 1'b0;
    endtask

    task automatic load_job(input logic [7:0] w0, input logic [7:0] w1,
                            input logic [7:0] w2, input int n, input bit answer_done,
                            input int exp_res, input string req);
        pulse_start();
        chk("R2 strobe active", int'(prog_o), 0);
        chk("R2 busy raised", int'(busy_o), 1);
        chk("R6 no ready before load", int'(cfg_ready), 0);
        repeat (3) @(negedge clk);
        init_i = 1'b0;
        wait_prog(1'b1);
        chk("R4 strobe released while busy", int'(busy_o), 1);
        repeat (3) @(negedge clk);
        init_i = 1'b1;
        send_words(w0, w1, w2, n);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        if (answer_done) done_i = 1'b1;
        wait_idle();
        chk(req, int'(result_o), exp_res);
        chk("R6 all bits sent", exp_q.size(), 0);
        done_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy idle", int'(busy_o), 0);
        chk("R1 strobe idle", int'(prog_o), 1);
        chk("R1 clock idle", int'(cclk_o), 1);
        chk("R1 data idle", int'(sdata_o), 1);
        chk("R1 result reset", int'(result_o), 0);

        // init never clears: exact window, with an ignored second start
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cnt = 0;
        while (busy_o) begin
            cnt++;
            if (cnt == 5) start = 1'b1;
            if (cnt == 6) start = 1'b0;
            @(negedge clk);
        end
        chk("R3 result code", int'(result_o), 1);
        chk("R9 busy window", cnt, WINDOW);
        chk("R10 second start ignored, busy length", cnt, WINDOW);
        @(negedge clk);
        chk("R10 no restart after end", int'(busy_o), 0);
        chk("R3 strobe back inactive", int'(prog_o), 1);

        // successful load
        load_job(8'hA5, 8'h3C, 8'h00, 2, 1'b1, 0, "R8 success result");

        // init never returns high
        pulse_start();
        repeat (3) @(negedge clk);
        init_i = 1'b0;
        wait_prog(1'b1);
        chk("R4 busy after release", int'(busy_o), 1);
        wait_idle();
        chk("R4 result code", int'(result_o), 2);
        init_i = 1'b1;
        repeat (4) @(negedge clk);

        // done never rises
        load_job(8'hFF, 8'h81, 8'h00, 2, 1'b0, 3, "R7 result code");

        // second success with other patterns
        load_job(8'h00, 8'hFF, 8'h81, 3, 1'b1, 0, "R8 success after error");
        chk("R1 idle after job", int'(cclk_o) + int'(sdata_o) + int'(prog_o), 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule